// File: doc/BRIEF.md
# Predicate Mask Register File and Logic Unit

This block holds eight 64-bit predicate masks and executes the mask-only operations a vector core needs between vector instructions. These are the bitwise functions, a modular add, shifts by an immediate count, merging two half-width masks into one of double width, moves to and from a 64-bit general-purpose value, and two test operations that produce a zero flag and a carry flag. Every operation runs at a chosen width of 8, 16, 32 or 64 bits. Operands are cut to that width before use, and the result is zero-extended to 64 bits.

Each cycle the surrounding pipeline presents one operation. It supplies two source register indices, one destination index, a 4-bit operation code, a 2-bit width code, an 8-bit immediate and a 64-bit general-purpose input, and it raises `op_valid`. The two source indices also drive two combinational read ports, so the caller can see register contents directly. A result is stored at the clock edge. Test results go to a pair of flag flops, and a move to the general-purpose side loads an output register. Register 0 stores data like any other entry: treating it as "no predicate" is left to the vector datapath.

Top module: `mask_unit`

## Requirements
- R1: There are eight 64-bit registers, indexed 0 to 7. `rd_a_data` and `rd_b_data` show the registers selected by `src_a` and `src_b` without a clock delay. Register 0 is written and read like every other entry.
- R2: A register write takes effect at the rising clock edge on which `op_valid` is high. Before that edge, a read of the destination returns the old value.
- R3: `width_sel` 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits. Source operands are truncated to that width, and every stored or output result has zeros above it.
- R4: The bitwise codes are 0 AND (a & b), 1 AND-NOT (~a & b), 2 OR, 3 XOR, 4 XNOR and 5 NOT (~a). Each writes `dst`.
- R5: Code 6 writes (a + b) modulo 2^width to `dst`. The carry out of the selected width is dropped.
- R6: Code 7 shifts a left and code 8 shifts a right (logical) by `imm`, writing to `dst`. A count equal to or greater than the width gives zero.
- R7: Code 9 (unpack) writes a value of the selected width. Its upper half is the low half-width of a, and its lower half is the low half-width of b.
- R8: Code 10 copies a to `dst`. Code 11 writes `gpr_in` to `dst`. Code 12 loads a into `gpr_out` and writes no register. All three use the width rule of R3.
- R9: Code 13 (OR-test) sets `flag_zero` when (a | b) is all zeros at the width, and sets `flag_carry` when it is all ones at the width.
- R10: Code 14 (AND-test) sets `flag_zero` when (a & b) is zero, and sets `flag_carry` when (~a & b) is zero, both at the width.
- R11: The test codes write no register. Every other code leaves the flags unchanged. With `op_valid` low, or with code 15, nothing changes.
- R12: While reset is active and after it is released, every register, both flags and `gpr_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Execute the presented operation at this edge |
| op_code | input | 4 | Operation code (see R4 to R11) |
| width_sel | input | 2 | Operation width: 8, 16, 32 or 64 bits |
| src_a | input | 3 | First source index and read port A select |
| src_b | input | 3 | Second source index and read port B select |
| dst | input | 3 | Destination register index |
| imm | input | 8 | Shift count |
| gpr_in | input | 64 | General-purpose value for code 11 |
| rd_a_data | output | 64 | Contents of register `src_a` |
| rd_b_data | output | 64 | Contents of register `src_b` |
| gpr_out | output | 64 | Result of the last code 12 |
| flag_zero | output | 1 | Zero flag from the last test operation |
| flag_carry | output | 1 | Carry flag from the last test operation |

## Verification
The bench aims at the width boundaries. An 8-bit add that overflows must wrap to a single byte. Shift counts equal to the width and far past it must give zero, and a 63-bit left shift must keep only the top bit. A design that masked only the result, or shifted before truncating, would leak upper bits into these cases. Unpack is checked at the narrowest and widest widths, where swapping the sources or taking the wrong half shows as a plainly wrong pattern. Both test operations are driven into all-zero, all-ones and mixed cases, so a swapped flag or an AND-NOT with its operands reversed flips a flag. The bench also checks that test operations leave the register named as destination intact, that other operations keep the flags, and that a read in the write cycle still sees the old value.

// File: rtl/mask_pkg.sv
package mask_pkg;
  localparam int MW   = 64;
  localparam int NREG = 8;
  localparam int AW   = $clog2(NREG);
  localparam int IMMW = 8;
  localparam int WBW  = $clog2(MW) + 1;

  typedef enum logic [3:0] {
    KOP_AND    = 4'd0,
    KOP_ANDN   = 4'd1,
    KOP_OR     = 4'd2,
    KOP_XOR    = 4'd3,
    KOP_XNOR   = 4'd4,
    KOP_NOT    = 4'd5,
    KOP_ADD    = 4'd6,
    KOP_SHL    = 4'd7,
    KOP_SHR    = 4'd8,
    KOP_UNPK   = 4'd9,
    KOP_COPY   = 4'd10,
    KOP_LDG    = 4'd11,
    KOP_STG    = 4'd12,
    KOP_ORTST  = 4'd13,
    KOP_ANDTST = 4'd14,
    KOP_NOP    = 4'd15
  } kop_e;

  function automatic logic [WBW-1:0] width_bits(input logic [1:0] ws);
    return WBW'(8) << ws;
  endfunction

  function automatic logic [MW-1:0] width_mask(input logic [1:0] ws);
    return {MW{1'b1}} >> (MW - int'(width_bits(ws)));
  endfunction
endpackage

// File: rtl/mask_rst_sync.sv
module mask_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mask_regfile.sv
module mask_regfile #(
  parameter int NREG = mask_pkg::NREG,
  parameter int MW   = mask_pkg::MW,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [MW-1:0] wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [MW-1:0] rda,
  output logic [MW-1:0] rdb
);
  logic [MW-1:0] entry [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic          ld;
    logic [MW-1:0] q;
    logic [MW-1:0] d;

    assign ld = we && (waddr == AW'(i));

    always_comb begin
      d = ld ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign entry[i] = q;
  end

  assign rda = entry[ra];
  assign rdb = entry[rb];
endmodule

// File: rtl/mask_alu.sv
module mask_alu
  import mask_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [1:0]      ws,
  input  logic [MW-1:0]   a,
  input  logic [MW-1:0]   b,
  input  logic [IMMW-1:0] imm,
  input  logic [MW-1:0]   gpr_in,
  output logic [MW-1:0]   res,
  output logic            wr_req,
  output logic            tst_req,
  output logic            stg_req,
  output logic            z_new,
  output logic            c_new
);
  kop_e           kop;
  logic [WBW-1:0] wbits;
  logic [WBW-1:0] half;
  logic [MW-1:0]  wm;
  logic [MW-1:0]  hm;
  logic [MW-1:0]  am;
  logic [MW-1:0]  bm;
  logic           sh_ok;
  logic [MW-1:0]  orv;

  always_comb begin
    kop   = kop_e'(op);
    wbits = width_bits(ws);
    half  = wbits >> 1;
    wm    = width_mask(ws);
    hm    = wm >> half;
    am    = a & wm;
    bm    = b & wm;
    sh_ok = int'(imm) < int'(wbits);
    orv   = am | bm;

    res     = '0;
    wr_req  = 1'b1;
    tst_req = 1'b0;
    stg_req = 1'b0;
    z_new   = 1'b0;
    c_new   = 1'b0;

    unique case (kop)
      KOP_AND:  res = am & bm;
      KOP_ANDN: res = ~am & bm;
      KOP_OR:   res = orv;
      KOP_XOR:  res = am ^ bm;
      KOP_XNOR: res = ~(am ^ bm) & wm;
      KOP_NOT:  res = ~am & wm;
      KOP_ADD:  res = (am + bm) & wm;
      KOP_SHL:  res = sh_ok ? ((am << imm) & wm) : '0;
      KOP_SHR:  res = sh_ok ? (am >> imm) : '0;
      KOP_UNPK: res = ((a & hm) << half) | (b & hm);
      KOP_COPY: res = am;
      KOP_LDG:  res = gpr_in & wm;
      KOP_STG: begin
        res     = am;
        wr_req  = 1'b0;
        stg_req = 1'b1;
      end
      KOP_ORTST: begin
        wr_req  = 1'b0;
        tst_req = 1'b1;
        z_new   = (orv == '0);
        c_new   = (orv == wm);
      end
      KOP_ANDTST: begin
        wr_req  = 1'b0;
        tst_req = 1'b1;
        z_new   = ((am & bm) == '0);
        c_new   = ((~am & bm) == '0);
      end
      default: wr_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/mask_outregs.sv
module mask_outregs #(
  parameter int MW = mask_pkg::MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_en,
  input  logic          z_new,
  input  logic          c_new,
  input  logic          gpr_en,
  input  logic [MW-1:0] gpr_new,
  output logic          flag_zero,
  output logic          flag_carry,
  output logic [MW-1:0] gpr_out
);
  logic          z_q, c_q, z_d, c_d;
  logic [MW-1:0] g_q, g_d;

  always_comb begin
    z_d = flag_en ? z_new : z_q;
    c_d = flag_en ? c_new : c_q;
    g_d = gpr_en ? gpr_new : g_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
      g_q <= '0;
    end else begin
      z_q <= z_d;
      c_q <= c_d;
      g_q <= g_d;
    end
  end

  assign flag_zero  = z_q;
  assign flag_carry = c_q;
  assign gpr_out    = g_q;
endmodule

// File: rtl/mask_unit.sv
module mask_unit
  import mask_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [1:0]      width_sel,
  input  logic [AW-1:0]   src_a,
  input  logic [AW-1:0]   src_b,
  input  logic [AW-1:0]   dst,
  input  logic [IMMW-1:0] imm,
  input  logic [MW-1:0]   gpr_in,
  output logic [MW-1:0]   rd_a_data,
  output logic [MW-1:0]   rd_b_data,
  output logic [MW-1:0]   gpr_out,
  output logic            flag_zero,
  output logic            flag_carry
);
  logic          srst_n;
  logic [MW-1:0] alu_res;
  logic          wr_req, tst_req, stg_req;
  logic          z_new, c_new;
  logic          rf_we, flag_en, gpr_en;

  mask_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  mask_regfile #(.NREG(NREG), .MW(MW)) u_rf (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (rf_we),
    .waddr (dst),
    .wdata (alu_res),
    .ra    (src_a),
    .rb    (src_b),
    .rda   (rd_a_data),
    .rdb   (rd_b_data)
  );

  mask_alu u_alu (
    .op      (op_code),
    .ws      (width_sel),
    .a       (rd_a_data),
    .b       (rd_b_data),
    .imm     (imm),
    .gpr_in  (gpr_in),
    .res     (alu_res),
    .wr_req  (wr_req),
    .tst_req (tst_req),
    .stg_req (stg_req),
    .z_new   (z_new),
    .c_new   (c_new)
  );

  always_comb begin
    rf_we   = op_valid && wr_req;
    flag_en = op_valid && tst_req;
    gpr_en  = op_valid && stg_req;
  end

  mask_outregs #(.MW(MW)) u_out (
    .clk        (clk),
    .rst_n      (srst_n),
    .flag_en    (flag_en),
    .z_new      (z_new),
    .c_new      (c_new),
    .gpr_en     (gpr_en),
    .gpr_new    (alu_res),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .gpr_out    (gpr_out)
  );
endmodule

// File: rtl/mask_unit_chk.sv
module mask_unit_chk
  import mask_pkg::*;
(
  input logic            clk,
  input logic            srst_n,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic [1:0]      width_sel,
  input logic [AW-1:0]   src_a,
  input logic [AW-1:0]   dst,
  input logic [MW-1:0]   rd_a_data,
  input logic [MW-1:0]   rd_b_data,
  input logic [MW-1:0]   alu_res,
  input logic            rf_we,
  input logic [MW-1:0]   gpr_out,
  input logic            flag_zero,
  input logic            flag_carry
);
  logic [MW-1:0] chk_wm;
  logic          is_tst;

  always_comb begin
    case (width_sel)
      2'd0:    chk_wm = 64'h0000_0000_0000_00FF;
      2'd1:    chk_wm = 64'h0000_0000_0000_FFFF;
      2'd2:    chk_wm = 64'h0000_0000_FFFF_FFFF;
      default: chk_wm = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    is_tst = (op_code == 4'd13) || (op_code == 4'd14);
  end

  // R2: a stored result is visible on the read port after the edge
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!srst_n)
    rf_we |=> ((src_a == $past(dst)) |-> (rd_a_data == $past(alu_res))));

  // R3: nothing above the selected width reaches storage or gpr_out
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!srst_n)
    op_valid |-> ((alu_res & ~chk_wm) == '0));

  // R9: an all-zero OR at the width raises the zero flag
  a_r9_ortest_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && op_code == 4'd13 && ((rd_a_data | rd_b_data) & chk_wm) == '0) |=> flag_zero);

  // R11: test operations leave the registers alone
  a_r11_test_nowrite: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && is_tst) |=> ($stable(src_a) |-> $stable(rd_a_data)));

  // R11: only test operations move the flags
  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !(op_valid && is_tst) |=> ($stable(flag_zero) && $stable(flag_carry)));

  // R12: outputs held at zero during reset
  a_r12_reset_clear: assert property (@(posedge clk)
    !srst_n |-> (!flag_zero && !flag_carry && gpr_out == '0));
endmodule

bind mask_unit mask_unit_chk u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .width_sel  (width_sel),
  .src_a      (src_a),
  .dst        (dst),
  .rd_a_data  (rd_a_data),
  .rd_b_data  (rd_b_data),
  .alu_res    (alu_res),
  .rf_we      (rf_we),
  .gpr_out    (gpr_out),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry)
);

// File: tb/sim_mask_unit.sv
module sim_mask_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  width_sel;
  logic [2:0]  src_a, src_b, dst;
  logic [7:0]  imm;
  logic [63:0] gpr_in;
  logic [63:0] rd_a_data, rd_b_data, gpr_out;
  logic        flag_zero, flag_carry;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] V1 = 64'hF0F0_1234_5678_00FF;
  localparam logic [63:0] V2 = 64'h0FF0_FFFF_0000_0F0F;

  always #(CLK_P/2) clk = ~clk;

  mask_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .width_sel(width_sel), .src_a(src_a), .src_b(src_b), .dst(dst),
    .imm(imm), .gpr_in(gpr_in), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .gpr_out(gpr_out), .flag_zero(flag_zero), .flag_carry(flag_carry)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input logic [1:0] w, input logic [2:0] a,
                      input logic [2:0] b, input logic [2:0] d, input logic [7:0] im,
                      input logic [63:0] g);
    @(negedge clk);
    op_code = op; width_sel = w; src_a = a; src_b = b; dst = d; imm = im; gpr_in = g;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] idx, input logic [63:0] exp);
    src_a = idx;
    #1;
    check64(tag, rd_a_data, exp);
  endtask

  task automatic chk_flags(input string tag, input logic z, input logic c);
    #1;
    check64(tag, {62'd0, flag_zero, flag_carry}, {62'd0, z, c});
  endtask

  task automatic load_sources;
    exec(4'd11, 2'd3, 3'd0, 3'd0, 3'd1, 8'd0, V1);
    exec(4'd11, 2'd3, 3'd0, 3'd0, 3'd2, 8'd0, V2);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) chk_reg("R12 register clear", 3'(i), 64'd0);
    check64("R12 gpr_out clear", gpr_out, 64'd0);
    chk_flags("R12 flags clear", 1'b0, 1'b0);
  endtask

  task automatic t_reg0;
    exec(4'd11, 2'd3, 3'd0, 3'd0, 3'd0, 8'd0, 64'h1122_3344_5566_7788);
    chk_reg("R1 register 0 stores", 3'd0, 64'h1122_3344_5566_7788);
    src_b = 3'd0; src_a = 3'd1; #1;
    check64("R1 read port B", rd_b_data, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_logic;
    exec(4'd0, 2'd0, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 AND w8", 3'd3, 64'h0F);
    exec(4'd1, 2'd1, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 ANDN w16", 3'd3, 64'h0F00);
    exec(4'd2, 2'd2, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 OR w32", 3'd3, 64'h5678_0FFF);
    exec(4'd3, 2'd3, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 XOR w64", 3'd3, 64'hFF00_EDCB_5678_0FF0);
    exec(4'd4, 2'd0, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 XNOR w8", 3'd3, 64'h0F);
    exec(4'd5, 2'd1, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_reg("R4 NOT w16 / R3 zero-extend", 3'd3, 64'hFF00);
  endtask

  task automatic t_add;
    exec(4'd6, 2'd0, 3'd1, 3'd2, 3'd4, 8'd0, 64'd0);
    chk_reg("R5 ADD w8 wraps", 3'd4, 64'h0E);
    exec(4'd6, 2'd3, 3'd1, 3'd2, 3'd4, 8'd0, 64'd0);
    chk_reg("R5 ADD w64 drops carry", 3'd4, 64'h00E1_1233_5678_100E);
  endtask

  task automatic t_shift;
    exec(4'd7, 2'd1, 3'd1, 3'd0, 3'd5, 8'd4, 64'd0);
    chk_reg("R6 SHL w16 by 4", 3'd5, 64'h0FF0);
    exec(4'd8, 2'd2, 3'd1, 3'd0, 3'd5, 8'd8, 64'd0);
    chk_reg("R6 SHR w32 by 8", 3'd5, 64'h0056_7800);
    exec(4'd7, 2'd0, 3'd1, 3'd0, 3'd5, 8'd8, 64'd0);
    chk_reg("R6 SHL w8 by width", 3'd5, 64'd0);
    exec(4'd7, 2'd3, 3'd1, 3'd0, 3'd5, 8'd63, 64'd0);
    chk_reg("R6 SHL w64 by 63", 3'd5, 64'h8000_0000_0000_0000);
    exec(4'd8, 2'd3, 3'd1, 3'd0, 3'd5, 8'd200, 64'd0);
    chk_reg("R6 SHR w64 by 200", 3'd5, 64'd0);
  endtask

  task automatic t_unpack;
    exec(4'd9, 2'd1, 3'd1, 3'd2, 3'd6, 8'd0, 64'd0);
    chk_reg("R7 unpack w16", 3'd6, 64'hFF0F);
    exec(4'd9, 2'd3, 3'd1, 3'd2, 3'd6, 8'd0, 64'd0);
    chk_reg("R7 unpack w64", 3'd6, 64'h5678_00FF_0000_0F0F);
    exec(4'd9, 2'd0, 3'd2, 3'd1, 3'd6, 8'd0, 64'd0);
    chk_reg("R7 unpack w8", 3'd6, 64'hFF);
  endtask

  task automatic t_move;
    exec(4'd10, 2'd2, 3'd1, 3'd0, 3'd6, 8'd0, 64'd0);
    chk_reg("R8 copy w32", 3'd6, 64'h5678_00FF);
    exec(4'd11, 2'd1, 3'd0, 3'd0, 3'd6, 8'd0, 64'hABCD_1234_5678_9ABC);
    chk_reg("R8 load gpr w16", 3'd6, 64'h9ABC);
    exec(4'd12, 2'd3, 3'd2, 3'd0, 3'd6, 8'd0, 64'd0);
    #1 check64("R8 store gpr w64", gpr_out, V2);
    chk_reg("R8 store writes no register", 3'd6, 64'h9ABC);
    exec(4'd12, 2'd0, 3'd1, 3'd0, 3'd6, 8'd0, 64'd0);
    #1 check64("R8 store gpr w8", gpr_out, 64'hFF);
  endtask

  task automatic t_ortest;
    exec(4'd13, 2'd0, 3'd1, 3'd2, 3'd1, 8'd0, 64'd0);
    chk_flags("R9 ortest all ones", 1'b0, 1'b1);
    chk_reg("R11 ortest leaves dst", 3'd1, V1);
    exec(4'd13, 2'd1, 3'd1, 3'd2, 3'd1, 8'd0, 64'd0);
    chk_flags("R9 ortest mixed", 1'b0, 1'b0);
    exec(4'd13, 2'd0, 3'd7, 3'd7, 3'd1, 8'd0, 64'd0);
    chk_flags("R9 ortest zero", 1'b1, 1'b0);
  endtask

  task automatic t_andtest;
    exec(4'd14, 2'd0, 3'd1, 3'd2, 3'd2, 8'd0, 64'd0);
    chk_flags("R10 andtest Z0 C1", 1'b0, 1'b1);
    chk_reg("R11 andtest leaves dst", 3'd2, V2);
    exec(4'd14, 2'd1, 3'd2, 3'd1, 3'd2, 8'd0, 64'd0);
    chk_flags("R10 andtest Z0 C0", 1'b0, 1'b0);
    exec(4'd14, 2'd0, 3'd7, 3'd1, 3'd2, 8'd0, 64'd0);
    chk_flags("R10 andtest Z1 C0", 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    exec(4'd0, 2'd3, 3'd1, 3'd2, 3'd3, 8'd0, 64'd0);
    chk_flags("R11 non-test op keeps flags", 1'b1, 1'b0);
    @(negedge clk);
    op_code = 4'd11; width_sel = 2'd3; dst = 3'd3; gpr_in = 64'hDEAD; op_valid = 1'b0;
    @(negedge clk);
    chk_reg("R11 op_valid low no write", 3'd3, V1 & V2);
    exec(4'd15, 2'd3, 3'd1, 3'd2, 3'd3, 8'd0, 64'hDEAD);
    chk_reg("R11 code 15 no write", 3'd3, V1 & V2);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    op_code = 4'd11; width_sel = 2'd3; src_a = 3'd4; dst = 3'd4; gpr_in = 64'h55AA;
    op_valid = 1'b1;
    #1 check64("R2 old value before edge", rd_a_data, 64'h00E1_1233_5678_100E);
    @(posedge clk);
    #1 check64("R2 new value after edge", rd_a_data, 64'h55AA);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd15; width_sel = 2'd3;
    src_a = '0; src_b = '0; dst = '0; imm = '0; gpr_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reg0();
    load_sources();
    t_logic();
    t_add();
    t_shift();
    t_unpack();
    t_move();
    t_ortest();
    t_andtest();
    t_hold();
    t_same_cycle();
    finish_run();
  end
endmodule